// File: doc/BRIEF.md
# Single-Channel Gray-Indexed Command Cache

This block queues engine commands between a pusher and a puller. Each queued command carries a 3-bit subchannel id, an 11-bit method number and a 32-bit data word. The channel that owns the queued commands is not stored with each command. One current-channel register applies to the whole queue. A push names its channel. If that channel differs from the owner, the push is taken only when the owner can be replaced: the queue must be empty and channel switching must be enabled. Any push that cannot be taken raises a reject strobe in the same cycle, so the pusher can log it as a runout. The block never stalls a push.

The write and read indices step through Gray-code values. With the default `ADDR_W` of 5 there are 32 slots, and `ADDR_W` of 6 gives 64. Three enable bits gate the block: push access, pull enable and switch enable. They are loaded through a small configuration strobe. While the unit-enable input is low, all three are held cleared. The puller sees the head entry through a valid/ready handshake.

Top module: `cmd_cache`

## Requirements
- R1: Accepted commands leave the pull side in push order, each with the same subchannel, method and data values it was pushed with.
- R2: While push access is disabled, every push is rejected.
- R3: A push whose channel equals the current channel is accepted whenever push access is enabled and the queue is not full.
- R4: A push whose channel differs from the current channel is rejected while the queue holds any entry. The current channel does not change while the queue is non-empty.
- R5: A push whose channel differs from the current channel is rejected when switching is disabled, even if the queue is empty.
- R6: On an empty queue with switching enabled, a push on a different channel is accepted, and `chid_o` shows the new channel from the next cycle.
- R7: The queue reports full, and rejects every push through the reject strobe, once it holds 2^ADDR_W - 1 entries. Full means the next Gray write index would equal the read index.
- R8: `pull_valid_o` is high exactly when pull enable is set and the queue is not empty.
- R9: While `unit_en_i` is low, push access, pull enable and switch enable are cleared on the next edge, and configuration writes are ignored.
- R10: A push and a pop in the same cycle leave the occupancy unchanged. Empty is signalled when the write and read indices are equal.
- R11: `put_ptr_o` and `get_ptr_o` show the Gray code (b xor b>>1) of the number of pushes and pops, modulo 2^ADDR_W. Each advance changes exactly one bit.
- R12: After reset the queue is empty, both indices and `chid_o` are 0, all enables are clear and `pull_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unit_en_i | input | 1 | Unit enable; low clears the three enable bits |
| cfg_we_i | input | 1 | Load the enable bits from the cfg inputs |
| cfg_push_en_i | input | 1 | Push access value to load |
| cfg_pull_en_i | input | 1 | Pull enable value to load |
| cfg_chsw_en_i | input | 1 | Switch enable value to load |
| push_valid_i | input | 1 | Push request |
| push_chid_i | input | CHID_W | Channel of the push |
| push_subch_i | input | 3 | Subchannel id |
| push_mthd_i | input | 11 | Method number |
| push_data_i | input | 32 | Data word |
| push_accept_o | output | 1 | Push taken this cycle |
| push_reject_o | output | 1 | Push refused this cycle |
| pull_valid_o | output | 1 | Head entry available |
| pull_ready_i | input | 1 | Puller takes the head entry |
| pull_subch_o | output | 3 | Head subchannel id |
| pull_mthd_o | output | 11 | Head method |
| pull_data_o | output | 32 | Head data |
| chid_o | output | CHID_W | Current owning channel |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| put_ptr_o | output | ADDR_W | Gray write index |
| get_ptr_o | output | ADDR_W | Gray read index |

## Verification
The hardest case to reach is the full boundary while a pull happens at the same time. In that cycle the push must still be refused, because fullness is judged from the indices as registered, before the pop. The stimulus first fills the queue with the puller held off. It then pushes and pulls in the same cycle, and after that runs matched push/pull cycles that must keep the occupancy fixed. The bench also switches channels on an empty queue, with the switch enable both on and off. A random phase mixes two channels, readiness and short drops of unit enable, and a behavioural queue model is compared against the outputs every cycle.

// File: rtl/cmd_cache_pkg.sv
package cmd_cache_pkg;
  localparam int SUBCH_W = 3;
  localparam int MTHD_W  = 11;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic [SUBCH_W-1:0] subch;
    logic [MTHD_W-1:0]  mthd;
    logic [DATA_W-1:0]  data;
  } cmd_entry_t;
endpackage

// File: rtl/gray_ptr.sv
module gray_ptr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] gray_o,
  output logic [W-1:0] gray_nxt_o
);
  logic [W-1:0] gray_q, bin, bin_inc;

  // gray -> binary
  always_comb begin
    bin[W-1] = gray_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ gray_q[i];
  end

  assign bin_inc    = bin + W'(1);
  assign gray_nxt_o = bin_inc ^ (bin_inc >> 1);
  assign gray_o     = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gray_q <= '0;
    else if (adv_i) gray_q <= gray_nxt_o;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unit_en_i,
  input  logic cfg_we_i,
  input  logic cfg_push_en_i,
  input  logic cfg_pull_en_i,
  input  logic cfg_chsw_en_i,
  output logic push_en_o,
  output logic pull_en_o,
  output logic chsw_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_en_o <= 1'b0;
      pull_en_o <= 1'b0;
      chsw_en_o <= 1'b0;
    end else if (!unit_en_i) begin
      push_en_o <= 1'b0;
      pull_en_o <= 1'b0;
      chsw_en_o <= 1'b0;
    end else if (cfg_we_i) begin
      push_en_o <= cfg_push_en_i;
      pull_en_o <= cfg_pull_en_i;
      chsw_en_o <= cfg_chsw_en_i;
    end
  end
endmodule

// File: rtl/cache_store.sv
module cache_store
  import cmd_cache_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  cmd_entry_t    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output cmd_entry_t    rdata_o
);
  localparam int DEPTH = 1 << AW;

  cmd_entry_t mem [DEPTH];

  // slots are addressed by the gray index directly (bijective)
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cmd_cache.sv
module cmd_cache
  import cmd_cache_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CHID_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                unit_en_i,
  input  logic                cfg_we_i,
  input  logic                cfg_push_en_i,
  input  logic                cfg_pull_en_i,
  input  logic                cfg_chsw_en_i,
  input  logic                push_valid_i,
  input  logic [CHID_W-1:0]   push_chid_i,
  input  logic [SUBCH_W-1:0]  push_subch_i,
  input  logic [MTHD_W-1:0]   push_mthd_i,
  input  logic [DATA_W-1:0]   push_data_i,
  output logic                push_accept_o,
  output logic                push_reject_o,
  output logic                pull_valid_o,
  input  logic                pull_ready_i,
  output logic [SUBCH_W-1:0]  pull_subch_o,
  output logic [MTHD_W-1:0]   pull_mthd_o,
  output logic [DATA_W-1:0]   pull_data_o,
  output logic [CHID_W-1:0]   chid_o,
  output logic                empty_o,
  output logic                full_o,
  output logic [ADDR_W-1:0]   put_ptr_o,
  output logic [ADDR_W-1:0]   get_ptr_o
);
  logic push_en, pull_en, chsw_en;
  logic [ADDR_W-1:0] put_g, put_nxt, get_g, get_nxt;
  logic [CHID_W-1:0] cur_ch_q;
  logic ch_match, can_switch, pop;
  cmd_entry_t wr_entry, rd_entry;

  cache_ctrl u_ctrl (
    .clk_i, .rst_ni, .unit_en_i, .cfg_we_i,
    .cfg_push_en_i, .cfg_pull_en_i, .cfg_chsw_en_i,
    .push_en_o (push_en),
    .pull_en_o (pull_en),
    .chsw_en_o (chsw_en)
  );

  gray_ptr #(.W(ADDR_W)) u_put (
    .clk_i, .rst_ni,
    .adv_i      (push_accept_o),
    .gray_o     (put_g),
    .gray_nxt_o (put_nxt)
  );

  gray_ptr #(.W(ADDR_W)) u_get (
    .clk_i, .rst_ni,
    .adv_i      (pop),
    .gray_o     (get_g),
    .gray_nxt_o (get_nxt)
  );

  assign empty_o    = (put_g == get_g);
  assign full_o     = (put_nxt == get_g);
  assign ch_match   = (push_chid_i == cur_ch_q);
  assign can_switch = empty_o && chsw_en;

  // full is judged on registered indices: a same-cycle pop does not free a slot
  assign push_accept_o = push_valid_i && push_en && !full_o && (ch_match || can_switch);
  assign push_reject_o = push_valid_i && !push_accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cur_ch_q <= '0;
    else if (push_accept_o && !ch_match) cur_ch_q <= push_chid_i;
  end

  assign wr_entry = '{subch: push_subch_i, mthd: push_mthd_i, data: push_data_i};

  cache_store #(.AW(ADDR_W)) u_store (
    .clk_i,
    .we_i    (push_accept_o),
    .waddr_i (put_g),
    .wdata_i (wr_entry),
    .raddr_i (get_g),
    .rdata_o (rd_entry)
  );

  assign pull_valid_o = pull_en && !empty_o;
  assign pop          = pull_valid_o && pull_ready_i;
  assign pull_subch_o = rd_entry.subch;
  assign pull_mthd_o  = rd_entry.mthd;
  assign pull_data_o  = rd_entry.data;
  assign chid_o       = cur_ch_q;
  assign put_ptr_o    = put_g;
  assign get_ptr_o    = get_g;
endmodule

// File: rtl/cmd_cache_chk.sv
module cmd_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int CHID_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unit_en_i,
  input logic              push_valid_i,
  input logic [CHID_W-1:0] push_chid_i,
  input logic              push_accept_o,
  input logic              pull_valid_o,
  input logic              pull_ready_i,
  input logic [CHID_W-1:0] chid_o,
  input logic              empty_o,
  input logic              full_o,
  input logic [ADDR_W-1:0] put_ptr_o,
  input logic [ADDR_W-1:0] get_ptr_o
);
  AST_FULL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_accept_o); // R7

  AST_MISMATCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && !empty_o && push_chid_i != chid_o) |-> !push_accept_o); // R4

  AST_CHID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && $past(!empty_o)) |-> $stable(chid_o)); // R4

  AST_PULL_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_valid_o |-> !empty_o); // R8

  AST_UNIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en_i |=> (!pull_valid_o && !push_accept_o)); // R9

  AST_BOTH_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(push_accept_o) && $past(pull_valid_o && pull_ready_i))
      |-> (!$stable(put_ptr_o) && !$stable(get_ptr_o))); // R10

  AST_PUT_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(put_ptr_o) |-> $countones(put_ptr_o ^ $past(put_ptr_o)) == 1); // R11

  AST_GET_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(get_ptr_o) |-> $countones(get_ptr_o ^ $past(get_ptr_o)) == 1); // R11
endmodule

bind cmd_cache cmd_cache_chk #(.ADDR_W(ADDR_W), .CHID_W(CHID_W)) u_chk (.*);

// File: tb/cmd_cache_test.sv
module cmd_cache_test;
  localparam int AW = 5;
  localparam int CW = 7;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni, unit_en_i, cfg_we_i, cfg_push_en_i, cfg_pull_en_i, cfg_chsw_en_i;
  logic push_valid_i, pull_ready_i;
  logic [CW-1:0] push_chid_i;
  logic [2:0] push_subch_i;
  logic [10:0] push_mthd_i;
  logic [31:0] push_data_i;
  logic push_accept_o, push_reject_o, pull_valid_o, empty_o, full_o;
  logic [2:0] pull_subch_o;
  logic [10:0] pull_mthd_o;
  logic [31:0] pull_data_o;
  logic [CW-1:0] chid_o;
  logic [AW-1:0] put_ptr_o, get_ptr_o;

  cmd_cache #(.ADDR_W(AW), .CHID_W(CW)) uut (.*);

  int checks = 0, fails = 0;
  logic [45:0] q[$];
  int cur_ch = 0, put_cnt = 0, get_cnt = 0;
  bit m_push = 0, m_pull = 0, m_sw = 0;
  bit done = 0;

  function automatic int gray(int b);
    return b ^ (b >> 1);
  endfunction

  function automatic int g2b(logic [AW-1:0] g);
    int b = 0;
    for (int i = AW - 1; i >= 0; i--) b = b | ((((b >> (i + 1)) & 1) ^ int'(g[i])) << i);
    return b;
  endfunction

  task automatic chk_eq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // compare combinational and registered outputs, then step the model over one edge
  task automatic tick();
    int sz;
    bit fullm, match, acc, pv;
    string tag;
    #2;
    sz    = q.size();
    fullm = (sz == DEPTH - 1);
    match = (int'(push_chid_i) == cur_ch);
    acc   = push_valid_i && m_push && !fullm && (match || (sz == 0 && m_sw));
    if (!m_push)                tag = "R2";
    else if (fullm)             tag = "R7";
    else if (match)             tag = "R3";
    else if (sz != 0)           tag = "R4";
    else if (!m_sw)             tag = "R5";
    else                        tag = "R6";
    chk_eq(tag, "accept", push_accept_o, acc);
    chk_eq(tag, "reject", push_reject_o, push_valid_i && !acc);
    pv = m_pull && sz > 0;
    chk_eq("R8", "pull_valid", pull_valid_o, pv);
    if (pv) chk_eq("R1", "head", {pull_subch_o, pull_mthd_o, pull_data_o}, q[0]);
    chk_eq("R6", "chid", chid_o, cur_ch);
    chk_eq("R11", "put_ptr", put_ptr_o, gray(put_cnt % DEPTH));
    chk_eq("R11", "get_ptr", get_ptr_o, gray(get_cnt % DEPTH));
    chk_eq("R7", "full", full_o, fullm);
    chk_eq("R10", "empty", empty_o, sz == 0);
    @(posedge clk_i);
    if (pv && pull_ready_i) begin void'(q.pop_front()); get_cnt++; end
    if (acc) begin
      q.push_back({push_subch_i, push_mthd_i, push_data_i});
      put_cnt++;
      cur_ch = int'(push_chid_i);
    end
    if (!unit_en_i) begin m_push = 0; m_pull = 0; m_sw = 0; end
    else if (cfg_we_i) begin m_push = cfg_push_en_i; m_pull = cfg_pull_en_i; m_sw = cfg_chsw_en_i; end
    @(negedge clk_i);
  endtask

  task automatic set_push(bit v, int ch, bit rdy);
    push_valid_i = v;
    push_chid_i  = CW'(ch);
    push_subch_i = 3'($urandom);
    push_mthd_i  = 11'($urandom);
    push_data_i  = $urandom;
    pull_ready_i = rdy;
    cfg_we_i     = 1'b0;
  endtask

  task automatic step(bit v, int ch, bit rdy);
    set_push(v, ch, rdy);
    tick();
  endtask

  task automatic cfg(bit pe, bit le, bit sw);
    set_push(0, 0, 0);
    cfg_we_i = 1'b1; cfg_push_en_i = pe; cfg_pull_en_i = le; cfg_chsw_en_i = sw;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int occ;
    rst_ni = 0; unit_en_i = 1; cfg_we_i = 0; cfg_push_en_i = 0; cfg_pull_en_i = 0;
    cfg_chsw_en_i = 0; push_valid_i = 0; pull_ready_i = 0; push_chid_i = '0;
    push_subch_i = '0; push_mthd_i = '0; push_data_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #2;
    chk_eq("R12", "empty", empty_o, 1);
    chk_eq("R12", "pull_valid", pull_valid_o, 0);
    chk_eq("R12", "chid", chid_o, 0);
    chk_eq("R12", "ptrs", {put_ptr_o, get_ptr_o}, 0);
    @(negedge clk_i);
    step(1, 0, 0);                         // R12 enables clear: rejected
    cfg(1, 1, 1);
    for (int i = 0; i < 5; i++) step(1, 3, 0);   // R6 switch then R3
    step(1, 5, 0);                         // R4
    for (int i = 0; i < 5; i++) step(0, 0, 1);   // R1 drain
    cfg(1, 1, 0);
    step(1, 5, 0);                         // R5
    for (int i = 0; i < DEPTH; i++) step(1, 3, 0); // fill past full: R7
    step(1, 3, 1);                         // full + pop: push still refused
    occ = (g2b(put_ptr_o) - g2b(get_ptr_o)) & (DEPTH - 1);
    for (int i = 0; i < 6; i++) step(1, 3, 1);
    chk_eq("R10", "occupancy", (g2b(put_ptr_o) - g2b(get_ptr_o)) & (DEPTH - 1), occ);
    cfg(0, 1, 1);
    step(1, 3, 0);                         // R2
    cfg(1, 0, 1);
    step(0, 0, 1);                         // R8
    cfg(1, 1, 1);
    set_push(0, 0, 0);
    unit_en_i = 0; cfg_we_i = 1; cfg_push_en_i = 1; cfg_pull_en_i = 1; cfg_chsw_en_i = 1;
    tick();
    unit_en_i = 1;
    set_push(1, 3, 1);
    #2;
    chk_eq("R9", "accept after unit off", push_accept_o, 0);
    chk_eq("R9", "pull_valid after unit off", pull_valid_o, 0);
    tick();
    cfg(1, 1, 1);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 49) == 0) begin
        set_push(0, 0, 0);
        unit_en_i = 0;
        tick();
        unit_en_i = 1;
        cfg(1, 1, $urandom_range(0, 3) != 0);
      end else begin
        step($urandom_range(0, 2) != 0, $urandom_range(0, 7) == 0 ? 4 : 3,
             $urandom_range(0, 1) == 1);
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1);
    chk_eq("R10", "drained empty", empty_o, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule